// File: doc/BRIEF.md
# Display Sync Event Generator

This block sits beside a display timing generator and turns its vertical position into two programmable events. The timing generator reports which vertical phase it is in (sync, back porch, active video or front porch) and the line number inside that phase, and it pulses a strobe once per frame. One event drives a single-cycle fetch request toward a pixel fetch engine. The other sets a sticky interrupt flag that software clears.

Both events are programmed through one 32-bit configuration word, written through a small write port. Each event has a 16-bit slot in that word: a 2-bit phase code and a 14-bit line count. Writes land in a staging register. The whole word takes effect at the next frame strobe, so a change made in the middle of a frame never tears the current frame. A second write address clears the interrupt flag.

Top module: `sevt_gen`

## Requirements
- R1: `fetch_req` is a one-cycle pulse. It is high in the cycle after the first cycle of a frame in which `cur_phase` and `cur_line` equal the fetch event's programmed phase and count.
- R2: The phase codes are 0 for vertical sync, 1 for back porch, 2 for active video and 3 for front porch. The fetch event takes its phase from config bits 1:0 and its 14-bit count from bits 15:2.
- R3: The interrupt event takes its phase from config bits 17:16 and its 14-bit count from bits 31:18.
- R4: Each event fires at most once per frame. Matching is armed in the cycle after `frame_start`. Nothing fires before the first `frame_start` after reset.
- R5: `irq_pend` rises two cycles after the first matching cycle of the interrupt event. It then stays high through later frames until it is cleared.
- R6: A write to address 1 with bit 0 set clears `irq_pend`, and a write there with bit 0 clear has no effect. If the interrupt event sets the flag in the same cycle as a clear, the flag stays set.
- R7: If the programmed count is never reached inside the chosen phase, the event does not fire in that frame.
- R8: A write to address 0 is staged and takes effect at the next `frame_start`. The frame in progress keeps its old settings. A write in the same cycle as the strobe takes effect one frame later.
- R9: The two events are independent. Both may target the same phase and line, and then both fire.
- R10: After reset, both outputs are low and both programmed targets read as phase 0, count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe that begins each frame |
| cur_phase | input | 2 | Current vertical phase code |
| cur_line | input | 14 | Line number inside the current phase |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = configuration word, 1 = interrupt clear |
| wr_data | input | 32 | Write data |
| fetch_req | output | 1 | Fetch request pulse |
| irq_pend | output | 1 | Sticky interrupt flag |

## Verification
A software clear of the interrupt flag can land in the same cycle as the interrupt event setting it. The bench provokes this by issuing the clear write exactly one cycle after the matching line, which is the cycle in which the internal hit is registered. The flag must read high afterwards. A later write with bit 0 clear must leave the flag high, and a write with bit 0 set must bring it low.

// File: rtl/sevt_pkg.sv
package sevt_pkg;

    localparam int LINE_W  = 14;
    localparam int PH_W    = 2;
    localparam int SLOT_W  = PH_W + LINE_W;
    localparam int NUM_EVT = 2;
    localparam int REG_W   = SLOT_W * NUM_EVT;

    localparam int EVT_FETCH = 0;
    localparam int EVT_IRQ   = 1;

    localparam logic ADDR_CFG = 1'b0;
    localparam logic ADDR_CLR = 1'b1;

    typedef enum logic [PH_W-1:0] {
        PH_VSYNC  = 2'd0,
        PH_BPORCH = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FPORCH = 2'd3
    } vphase_e;

    typedef struct packed {
        vphase_e           phase;
        logic [LINE_W-1:0] count;
    } evt_cfg_t;

    function automatic evt_cfg_t slot_decode(input logic [SLOT_W-1:0] slot);
        evt_cfg_t c;
        c.phase = vphase_e'(slot[PH_W-1:0]);
        c.count = slot[SLOT_W-1:PH_W];
        return c;
    endfunction

endpackage

// File: rtl/sevt_cfg_regs.sv
module sevt_cfg_regs
    import sevt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       frame_start,
    output evt_cfg_t [NUM_EVT-1:0]     act_cfg
);

    logic [REG_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else if (wr_en && wr_addr == ADDR_CFG)
            stage_q <= wr_data;
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                act_cfg[g] <= '0;
            else if (frame_start)
                act_cfg[g] <= slot_decode(stage_q[g*SLOT_W +: SLOT_W]);
        end
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(act_cfg));

endmodule

// File: rtl/sevt_match.sv
module sevt_match
    import sevt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  vphase_e           cur_phase,
    input  logic [LINE_W-1:0] cur_line,
    input  evt_cfg_t          cfg,
    output logic              hit
);

    logic armed_q;
    logic match;

    assign match = armed_q && !frame_start &&
                   (cur_phase == cfg.phase) && (cur_line == cfg.count);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            hit     <= 1'b0;
        end else begin
            hit <= match;
            if (frame_start)
                armed_q <= 1'b1;
            else if (match)
                armed_q <= 1'b0;
        end
    end

    // R4
    once_per_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !frame_start) |=> !hit);

endmodule

// File: rtl/sevt_gen.sv
module sevt_gen
    import sevt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [1:0]        cur_phase,
    input  logic [13:0]       cur_line,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [31:0]       wr_data,
    output logic              fetch_req,
    output logic              irq_pend
);

    evt_cfg_t [NUM_EVT-1:0] act_cfg;
    logic     [NUM_EVT-1:0] hit;
    logic                   clr_req;
    vphase_e                phase_in;

    assign phase_in = vphase_e'(cur_phase);

    sevt_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .act_cfg     (act_cfg)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        sevt_match u_match (
            .clk         (clk),
            .rst         (rst),
            .frame_start (frame_start),
            .cur_phase   (phase_in),
            .cur_line    (cur_line),
            .cfg         (act_cfg[g]),
            .hit         (hit[g])
        );
    end

    assign fetch_req = hit[EVT_FETCH];
    assign clr_req   = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst)
            irq_pend <= 1'b0;
        else if (hit[EVT_IRQ])
            irq_pend <= 1'b1;
        else if (clr_req)
            irq_pend <= 1'b0;
    end

    // R1
    fetch_target_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> ($past(cur_phase) == $past(act_cfg[EVT_FETCH].phase)) &&
                      ($past(cur_line)  == $past(act_cfg[EVT_FETCH].count)));

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit[EVT_IRQ] |=> irq_pend);

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && !clr_req) |=> irq_pend);

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit[EVT_IRQ]) |=> !irq_pend);

endmodule

// File: tb/sim_sevt_gen.sv
`timescale 1ns/1ps
module sim_sevt_gen;

    localparam int CPL = 2;
    localparam int VS_L = 2, BP_L = 3, ACT_L = 6, FP_L = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic [1:0]  cur_phase;
    logic [13:0] cur_line;
    logic        wr_en;
    logic        wr_addr;
    logic [31:0] wr_data;
    logic        fetch_req;
    logic        irq_pend;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sevt_gen u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cur_phase(cur_phase), .cur_line(cur_line),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fetch_req(fetch_req), .irq_pend(irq_pend)
    );

    function automatic logic [31:0] mk(input int hp, input int hc, input int sp, input int sc);
        logic [31:0] w;
        w[1:0]   = 2'(hp);
        w[15:2]  = 14'(hc);
        w[17:16] = 2'(sp);
        w[31:18] = 14'(sc);
        return w;
    endfunction

    function automatic int plen(input int p);
        case (p)
            0: return VS_L;
            1: return BP_L;
            2: return ACT_L;
            default: return FP_L;
        endcase
    endfunction

    function automatic int tgt_idx(input int p, input int l);
        int off = 0;
        if (l >= plen(p)) return -1;
        for (int q = 0; q < p; q++) off += plen(q);
        return (off + l) * CPL;
    endfunction

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic run_frame(input int mid_at, input logic mid_addr, input logic [31:0] mid_data,
                             output int rcnt, output int ridx, output int iidx);
        int idx = 0;
        logic iprev;
        rcnt = 0; ridx = -1; iidx = -1;
        cur_phase = 2'd3; cur_line = 14'h3FFF; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        iprev = irq_pend;
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < plen(p); l++)
                for (int c = 0; c < CPL; c++) begin
                    cur_phase = 2'(p); cur_line = 14'(l);
                    if (idx == mid_at) begin
                        wr_en = 1'b1; wr_addr = mid_addr; wr_data = mid_data;
                    end else begin
                        wr_en = 1'b0; wr_data = '0;
                    end
                    @(negedge clk);
                    if (fetch_req) begin rcnt++; ridx = idx; end
                    if (irq_pend && !iprev && iidx < 0) iidx = idx;
                    iprev = irq_pend;
                    idx++;
                end
        wr_en = 1'b0; wr_data = '0;
        cur_phase = 2'd3; cur_line = 14'h3FFF;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            if (fetch_req) begin rcnt++; ridx = idx; end
            if (irq_pend && !iprev && iidx < 0) iidx = idx;
            iprev = irq_pend;
            idx++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; frame_start = 1'b0; cur_phase = '0; cur_line = '0;
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_int("R10", "fetch_req after reset", int'(fetch_req), 0);
        check_int("R10", "irq_pend after reset", int'(irq_pend), 0);
    endtask

    task automatic t_no_strobe();
        int seen = 0;
        wr(1'b0, mk(0, 0, 0, 0));
        cur_phase = 2'd0; cur_line = 14'd0;
        repeat (4) begin
            @(negedge clk);
            if (fetch_req || irq_pend) seen++;
        end
        check_int("R4", "events before first strobe", seen, 0);
    endtask

    task automatic t_basic();
        int rc, ri, ii;
        wr(1'b0, mk(2, 3, 1, 1));
        run_frame(-1, 1'b0, '0, rc, ri, ii);
        check_int("R1", "fetch pulse count", rc, 1);
        check_int("R2", "fetch position", ri, tgt_idx(2, 3));
        check_int("R3", "irq rise position", ii, tgt_idx(1, 1) + 1);
        check_int("R5", "irq still set after frame", int'(irq_pend), 1);
        wr(1'b1, 32'd1);
        check_int("R6", "irq cleared by write of 1", int'(irq_pend), 0);
    endtask

    task automatic t_shared();
        int rc, ri, ii;
        wr(1'b0, mk(0, 0, 0, 0));
        run_frame(-1, 1'b0, '0, rc, ri, ii);
        check_int("R9", "shared target fetch count", rc, 1);
        check_int("R9", "shared target fetch position", ri, 0);
        check_int("R9", "shared target irq position", ii, 1);
        wr(1'b1, 32'd1);
    endtask

    task automatic t_exceed();
        int rc, ri, ii;
        wr(1'b0, mk(2, ACT_L, 3, FP_L + 5));
        run_frame(-1, 1'b0, '0, rc, ri, ii);
        check_int("R7", "fetch count beyond phase", rc, 0);
        check_int("R7", "irq beyond phase", ii, -1);
    endtask

    task automatic t_midframe();
        int rc, ri, ii;
        wr(1'b0, mk(1, 2, 2, 0));
        run_frame(-1, 1'b0, '0, rc, ri, ii);
        wr(1'b1, 32'd1);
        run_frame(3, 1'b0, mk(3, 1, 0, 1), rc, ri, ii);
        check_int("R8", "old fetch target kept mid-frame", ri, tgt_idx(1, 2));
        check_int("R8", "old irq target kept mid-frame", ii, tgt_idx(2, 0) + 1);
        wr(1'b1, 32'd1);
        run_frame(-1, 1'b0, '0, rc, ri, ii);
        check_int("R8", "new fetch target next frame", ri, tgt_idx(3, 1));
        check_int("R8", "new irq target next frame", ii, tgt_idx(0, 1) + 1);
        check_int("R4", "one fetch per frame", rc, 1);
        wr(1'b1, 32'd1);
    endtask

    task automatic t_collide();
        int rc, ri, ii;
        wr(1'b0, mk(2, 0, 1, 1));
        run_frame(-1, 1'b0, '0, rc, ri, ii);
        wr(1'b1, 32'd1);
        check_int("R6", "irq cleared before collision", int'(irq_pend), 0);
        run_frame(tgt_idx(1, 1) + 1, 1'b1, 32'd1, rc, ri, ii);
        check_int("R6", "set wins over same-cycle clear", int'(irq_pend), 1);
        wr(1'b1, 32'd0);
        check_int("R6", "write of 0 leaves irq", int'(irq_pend), 1);
        wr(1'b1, 32'd1);
        check_int("R6", "write of 1 clears irq", int'(irq_pend), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_no_strobe();
        t_basic();
        t_shared();
        t_exceed();
        t_midframe();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule